// File: doc/BRIEF.md
# Servo Stripe Frequency Detector

This block watches a stream of signed equalized samples and recognises servo stripes by how often they peak. A sample counts as a qualified peak when it is a local extreme of one polarity and its magnitude is above a programmable threshold. At most one peak is counted in each half-cycle of the waveform. Qualified peaks are counted over an observation window of a programmable number of valid samples. When the count at the end of a window falls inside a ±25% band around a programmable nominal count, the stripe flag is set.

After a window that detects a stripe, the next window becomes a capture window. The largest sample magnitude seen during it is latched as the burst amplitude, and a valid bit is raised so that a controller can poll the value. The stripe flag reaches its output pin only when that output function is selected. The window length must be at least one sample.

Top module: `stripe_detector`

## Requirements
- R1: After reset, `stripe_out`, `amp_value` and `amp_valid` are all zero.
- R2: A sample is a qualified peak when it and both of its valid neighbours share a sign, where the sign is bit SMP_W-1 and zero counts as positive. Its magnitude must be strictly greater than the magnitude of each neighbour and strictly greater than `qual_thresh`. The peak is the middle sample, and it is seen when the sample after it arrives.
- R3: After a qualified peak is counted, later peaks of the same sign are not counted until a valid sample of the opposite sign arrives.
- R4: A window spans `win_len` valid samples. When it closes, the peak count including the closing sample is compared with lo = N - floor(N/4) and hi = N + floor(N/4), where N is `nominal`. The internal stripe flag is set when lo <= count <= hi and cleared otherwise. It changes one clock after the closing sample.
- R5: `stripe_out` equals the internal stripe flag AND `stripe_sel`.
- R6: When `enable` is low, the stripe flag clears at the next clock. The window, the peak history and any capture in progress all restart, and the first valid sample after re-enabling is sample 0 of a fresh window.
- R7: The window after a detecting window is a capture window. At its close, `amp_value` takes the largest magnitude of its samples and `amp_valid` goes to 1. The magnitude of the most negative code is 2^(SMP_W-1).
- R8: `amp_value` and `amp_valid` hold until the next capture completes. A `amp_clear` pulse sets both to zero at the next clock, and it wins over a capture that completes in the same cycle.
- R9: Samples with `smp_valid` low are ignored: they do not advance the window, form peaks or change the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Detector enable |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Signed equalized sample |
| qual_thresh | input | SMP_W | Unsigned qualification threshold |
| nominal | input | CNT_W | Nominal peak count per window |
| win_len | input | WIN_W | Window length in valid samples |
| stripe_sel | input | 1 | Selects the stripe function onto the output pin |
| amp_clear | input | 1 | Clears the held burst amplitude |
| stripe_out | output | 1 | Gated stripe flag |
| amp_value | output | SMP_W | Captured burst amplitude |
| amp_valid | output | 1 | Burst amplitude is valid |

## Verification
The bench drives counts that sit exactly on the lower and upper edges of the band and just outside them. A design that uses a strict comparison, or rounds the quarter of the nominal count differently, would give the wrong flag at one of these edges. A ripple pattern puts two same-sign maxima in one half-cycle. A detector without the half-cycle lock would count both and move the count out of the band. The bench also checks the most negative sample code as the burst maximum, invalid cycles that carry large garbage values, and a clear pulse that lands on the closing sample of a capture. These catch a sign-extension error, invalid samples leaking into the window, and a clear that loses against a capture completing in the same cycle.

// File: rtl/stripe_pkg.sv
`timescale 1ns/1ps
package stripe_pkg;
    localparam int SMP_W_DEF = 8;
    localparam int CNT_W_DEF = 8;
    localparam int WIN_W_DEF = 12;

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;
endpackage

// File: rtl/stripe_peak_qual.sv
`timescale 1ns/1ps
module stripe_peak_qual
    import stripe_pkg::*;
#(
    parameter int W = SMP_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] thresh_i,
    output logic         peak_o,
    output logic [W-1:0] mag_o
);
    function automatic logic [W-1:0] mag_of(input logic [W-1:0] v);
        return v[W-1] ? ((~v) + W'(1)) : v;
    endfunction

    typedef struct packed {
        logic [W-1:0] h1;
        logic [W-1:0] h2;
        logic [1:0]   fill;
        logic         lock;
        sign_e        lsgn;
    } qst_t;

    qst_t st_q, st_d;

    logic [W-1:0] m1, m2;
    sign_e s0, s1, s2;
    logic  cand;

    always_comb begin
        st_d  = st_q;
        mag_o = mag_of(data_i);
        m1    = mag_of(st_q.h1);
        m2    = mag_of(st_q.h2);
        s0    = sign_e'(data_i[W-1]);
        s1    = sign_e'(st_q.h1[W-1]);
        s2    = sign_e'(st_q.h2[W-1]);
        cand  = enable_i && valid_i && (st_q.fill == 2'd2)
                && (s0 == s1) && (s1 == s2)
                && (m1 > m2) && (m1 > mag_o) && (m1 > thresh_i)
                && !(st_q.lock && (st_q.lsgn == s1));
        peak_o = cand;
        if (!enable_i) begin
            st_d = '0;
        end else if (valid_i) begin
            st_d.h2 = st_q.h1;
            st_d.h1 = data_i;
            if (st_q.fill != 2'd2) st_d.fill = st_q.fill + 2'd1;
            if (cand) begin
                st_d.lock = 1'b1;
                st_d.lsgn = s1;
            end else if (st_q.lock && (s0 != st_q.lsgn)) begin
                st_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !valid_i) |=> $stable(st_q.h1) && $stable(st_q.h2));

    // R3
    lock_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |=> st_q.lock);
endmodule

// File: rtl/stripe_window.sv
`timescale 1ns/1ps
module stripe_window
    import stripe_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int WIN_W = WIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             valid_i,
    input  logic             peak_i,
    input  logic [CNT_W-1:0] nominal_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             close_o,
    output logic             detect_o,
    output logic             stripe_o
);
    localparam int CMP_W = ((WIN_W > CNT_W) ? WIN_W : CNT_W) + 2;

    typedef struct packed {
        logic [WIN_W-1:0] wcnt;
        logic [WIN_W-1:0] pcnt;
        logic             stripe;
    } wst_t;

    wst_t st_q, st_d;

    logic [CMP_W-1:0] total, nom_x, quarter, lo, hi;
    logic inband;

    always_comb begin
        st_d     = st_q;
        close_o  = enable_i && valid_i && (st_q.wcnt == (win_len_i - WIN_W'(1)));
        total    = CMP_W'(st_q.pcnt) + CMP_W'(peak_i);
        nom_x    = CMP_W'(nominal_i);
        quarter  = nom_x >> 2;
        lo       = nom_x - quarter;
        hi       = nom_x + quarter;
        inband   = (total >= lo) && (total <= hi);
        detect_o = close_o && inband;
        if (!enable_i) begin
            st_d = '0;
        end else if (valid_i) begin
            if (close_o) begin
                st_d.wcnt   = '0;
                st_d.pcnt   = '0;
                st_d.stripe = inband;
            end else begin
                st_d.wcnt = st_q.wcnt + WIN_W'(1);
                st_d.pcnt = st_q.pcnt + WIN_W'(peak_i);
            end
        end
    end

    assign stripe_o = st_q.stripe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    stripe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stripe) |-> $past(close_o));

    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !st_q.stripe && (st_q.wcnt == '0));

    // R4
    peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pcnt <= st_q.wcnt);

    // R9
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !valid_i) |=> $stable(st_q.wcnt) && $stable(st_q.stripe));
endmodule

// File: rtl/stripe_burst_cap.sv
`timescale 1ns/1ps
module stripe_burst_cap
    import stripe_pkg::*;
#(
    parameter int W = SMP_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         valid_i,
    input  logic [W-1:0] mag_i,
    input  logic         close_i,
    input  logic         detect_i,
    input  logic         clear_i,
    output logic [W-1:0] amp_o,
    output logic         amp_vld_o
);
    typedef struct packed {
        logic         active;
        logic [W-1:0] runmax;
        logic [W-1:0] amp;
        logic         amp_vld;
    } cst_t;

    cst_t st_q, st_d;
    logic [W-1:0] best;

    always_comb begin
        st_d = st_q;
        best = (mag_i > st_q.runmax) ? mag_i : st_q.runmax;
        if (!enable_i) begin
            st_d.active = 1'b0;
            st_d.runmax = '0;
        end else if (valid_i) begin
            if (close_i) begin
                if (st_q.active) begin
                    st_d.amp     = best;
                    st_d.amp_vld = 1'b1;
                end
                st_d.active = detect_i;
                st_d.runmax = '0;
            end else if (st_q.active) begin
                st_d.runmax = best;
            end
        end
        if (clear_i) begin
            st_d.amp     = '0;
            st_d.amp_vld = 1'b0;
        end
    end

    assign amp_o     = st_q.amp;
    assign amp_vld_o = st_q.amp_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !st_q.amp_vld && (st_q.amp == '0));

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.amp_vld) |-> $past(close_i));

    // R8
    amp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !close_i) |=> $stable(st_q.amp) && $stable(st_q.amp_vld));
endmodule

// File: rtl/stripe_detector.sv
`timescale 1ns/1ps
module stripe_detector
    import stripe_pkg::*;
#(
    parameter int SMP_W = SMP_W_DEF,
    parameter int CNT_W = CNT_W_DEF,
    parameter int WIN_W = WIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] qual_thresh,
    input  logic [CNT_W-1:0] nominal,
    input  logic [WIN_W-1:0] win_len,
    input  logic             stripe_sel,
    input  logic             amp_clear,
    output logic             stripe_out,
    output logic [SMP_W-1:0] amp_value,
    output logic             amp_valid
);
    logic             peak_w, close_w, detect_w, stripe_w;
    logic [SMP_W-1:0] mag_w;

    stripe_peak_qual #(.W(SMP_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .valid_i  (smp_valid),
        .data_i   (smp_data),
        .thresh_i (qual_thresh),
        .peak_o   (peak_w),
        .mag_o    (mag_w)
    );

    stripe_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .valid_i   (smp_valid),
        .peak_i    (peak_w),
        .nominal_i (nominal),
        .win_len_i (win_len),
        .close_o   (close_w),
        .detect_o  (detect_w),
        .stripe_o  (stripe_w)
    );

    stripe_burst_cap #(.W(SMP_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .valid_i   (smp_valid),
        .mag_i     (mag_w),
        .close_i   (close_w),
        .detect_i  (detect_w),
        .clear_i   (amp_clear),
        .amp_o     (amp_value),
        .amp_vld_o (amp_valid)
    );

    assign stripe_out = stripe_w & stripe_sel;

    // R5
    gate_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stripe_sel |-> !stripe_out);
endmodule

// File: tb/sim_stripe_detector.sv
`timescale 1ns/1ps
module sim_stripe_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, sv = 1'b0, sel = 1'b0, clr = 1'b0;
    logic [7:0] sd = '0, th = '0;
    logic [7:0] nom = '0;
    logic [11:0] wl = '0;
    logic       so, ampv;
    logic [7:0] amp;

    int checks = 0, errors = 0;

    stripe_detector u0 (
        .clk(clk), .rst_n(rst_n), .enable(en), .smp_valid(sv), .smp_data(sd),
        .qual_thresh(th), .nominal(nom), .win_len(wl), .stripe_sel(sel),
        .amp_clear(clr), .stripe_out(so), .amp_value(amp), .amp_valid(ampv)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    st;
        int    av_amp;
        bit    av;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    int h1 = 0, h2 = 0, hc = 0, lk = 0, lsg = 0;
    int wc = 0, pc = 0, mst = 0, cap = 0, rmax = 0, mamp = 0, mampv = 0;

    function automatic int magi(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int sgn(input int x);
        return (x < 0) ? 1 : 0;
    endfunction

    function automatic int tri_s(input int t, input int p, input int a);
        int u, hh, qq, d;
        u  = t % p;
        hh = p / 2;
        qq = p / 4;
        if (u < hh) begin
            d = (u > qq) ? u - qq : qq - u;
            return a - d * a / qq;
        end
        d = (u - hh > qq) ? u - hh - qq : qq - (u - hh);
        return -(a - d * a / qq);
    endfunction

    task automatic drive(input bit v, input int x, input bit c, input string tag);
        exp_t e;
        int pk, n, lo, hi, tot, m1;
        sv = v; sd = 8'(x); clr = c;
        if (!en) begin
            hc = 0; lk = 0; wc = 0; pc = 0; mst = 0; cap = 0; rmax = 0;
        end else if (v) begin
            m1 = magi(h1);
            pk = (hc == 2 && sgn(h1) == sgn(h2) && sgn(h1) == sgn(x) &&
                  m1 > magi(h2) && m1 > magi(x) && m1 > int'(th) &&
                  !(lk == 1 && lsg == sgn(h1))) ? 1 : 0;
            if (pk == 1) begin lk = 1; lsg = sgn(h1); end
            else if (lk == 1 && sgn(x) != lsg) lk = 0;
            if (wc == int'(wl) - 1) begin
                tot = pc + pk;
                n = int'(nom);
                lo = n - n / 4;
                hi = n + n / 4;
                mst = (tot >= lo && tot <= hi) ? 1 : 0;
                if (cap == 1) begin
                    mamp = (magi(x) > rmax) ? magi(x) : rmax;
                    mampv = 1;
                end
                cap = mst; rmax = 0; wc = 0; pc = 0;
            end else begin
                wc++; pc += pk;
                if (cap == 1 && magi(x) > rmax) rmax = magi(x);
            end
            h2 = h1; h1 = x;
            if (hc < 2) hc++;
        end
        if (c) begin mamp = 0; mampv = 0; end
        e.st = (mst == 1) && sel;
        e.av_amp = mamp;
        e.av = (mampv == 1);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_tri(input int p, input int a, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) drive(1'b1, tri_s(i, p, a), 1'b0, tag);
    endtask

    task automatic realign();
        en = 1'b0;
        drive(1'b1, 0, 1'b0, "R6");
        en = 1'b1;
    endtask

    // monitor: scoreboard pop away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (so !== e.st || amp !== 8'(e.av_amp) || ampv !== e.av) begin
                    errors++;
                    $display("FAIL %s: actual stripe=%0b amp=%0d valid=%0b expected stripe=%0b amp=%0d valid=%0b",
                             e.tag, so, amp, ampv, e.st, e.av_amp, e.av);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int rip[8] = '{0, 50, 40, 60, 0, -50, -70, -50};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (so !== 1'b0 || amp !== 8'd0 || ampv !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual stripe=%0b amp=%0d valid=%0b expected 0 0 0", so, amp, ampv);
        end
        th = 8'd20; nom = 8'd8; wl = 12'd32; sel = 1'b1; en = 1'b1;
        // R4 in-band detection, R7 capture in following window
        run_tri(8, 100, 64, "R4 R7");
        // R5 output gating
        sel = 1'b0;
        run_tri(8, 100, 8, "R5");
        sel = 1'b1;
        run_tri(8, 100, 8, "R5");
        // R4 out of band (too few peaks)
        run_tri(16, 100, 64, "R4");
        // R2 below threshold
        realign();
        run_tri(8, 15, 64, "R2");
        // R3 ripple within a half-cycle
        realign();
        for (int i = 0; i < 64; i++) drive(1'b1, rip[i % 8], 1'b0, "R3");
        // R4 band edges
        nom = 8'd7;  realign(); run_tri(8, 100, 32, "R4 upper edge in");
        nom = 8'd10; realign(); run_tri(8, 100, 32, "R4 lower edge in");
        nom = 8'd6;  realign(); run_tri(8, 100, 32, "R4 above band");
        nom = 8'd11; realign(); run_tri(8, 100, 32, "R4 below band");
        nom = 8'd8;
        // R9 invalid cycles carry garbage
        realign();
        for (int i = 0; i < 64; i++) begin
            drive(1'b1, tri_s(i, 8, 100), 1'b0, "R9");
            drive(1'b0, 127, 1'b0, "R9");
            drive(1'b0, -128, 1'b0, "R9");
        end
        // R7 most negative code captured; R8 held afterwards
        realign();
        run_tri(8, 100, 32, "R7");
        for (int i = 0; i < 32; i++)
            drive(1'b1, (i == 10) ? -128 : tri_s(i, 8, 10), 1'b0, "R7");
        for (int i = 0; i < 64; i++) drive(1'b1, 0, 1'b0, "R8 hold");
        // R8 lone clear
        drive(1'b1, 0, 1'b1, "R8 clear");
        run_tri(8, 100, 4, "R8");
        // R8 clear on the closing sample of a capture window
        realign();
        for (int i = 0; i < 64; i++)
            drive(1'b1, tri_s(i, 8, 90), (i == 63), "R8 clear vs capture");
        run_tri(8, 90, 32, "R8 next capture");
        // R6 disable mid-stripe
        en = 1'b0;
        for (int i = 0; i < 3; i++) drive(1'b1, tri_s(i, 8, 90), 1'b0, "R6");
        en = 1'b1;
        run_tri(8, 90, 40, "R6");
        for (int i = 0; i < 3; i++) drive(1'b0, 0, 1'b0, "R9");
        @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule